// File: doc/BRIEF.md
# Byte-Serial Accumulator Fetch-Execute Controller

This block sequences a minimal accumulator machine through a single-byte-wide synchronous memory. Every memory transfer moves one byte. An instruction that names a 16-bit memory operand therefore costs three fetch reads: one for the opcode and one for each address byte, with the high byte first. A data read or a data write follows those three reads. Internally the block keeps a program counter, an address register that drives the memory address pins, a buffer register that catches returned bytes, an instruction register and an accumulator.

The block supports five instructions: load the accumulator, store the accumulator, no-operation, halt, and return from interrupt. It has one level-sensitive interrupt request. The request is examined only at the boundary between instructions. When it is taken, the block saves the program counter, masks further requests, pulses an acknowledge and continues fetching from a fixed vector. A memory read strobed in one cycle returns its byte in the next cycle.

Top module: `acc_fetch_ctrl`

## Requirements
- R1: While reset is low, the read strobe, the write strobe and the acknowledge are all low. After reset is released, the first read is at RESET_PC (default 0xFEDC).
- R2: Each fetch read uses the program counter as its address, and the counter advances by one after each fetch read. Opcode 0x01 (load) and opcode 0x02 (store) each fetch two more bytes after the opcode, high address byte first, so each takes three fetch reads.
- R3: Load (0x01) reads the byte at the fetched 16-bit address and places it in the accumulator.
- R4: Store (0x02) asserts the write strobe once, at the fetched 16-bit address, with the accumulator value on the write data pins.
- R5: Opcode 0x00, and any opcode not named in R2, R7 or R10, performs only its single opcode read and has no other effect.
- R6: The program counter wraps from 0xFFFF to 0x0000 in the middle of an instruction's fetch reads.
- R7: After halt (0xFF), no read or write strobe appears until an enabled interrupt request arrives.
- R8: An enabled request is taken only between instructions. Taking it raises the acknowledge for exactly one cycle, and the next fetch is at VECTOR (default 0x0010). An enabled request also ends a halt.
- R9: Taking an interrupt clears the enable flag. While the flag is clear, a request that stays high produces no further acknowledge.
- R10: Return (0x10) restores the program counter saved when the interrupt was taken and sets the enable flag again.
- R11: The read strobe and the write strobe are never high in the same cycle, and two reads are never strobed in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; the data arrives the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data, taken from the accumulator |
| mem_rdata | input | 8 | Read data from memory |
| irq_req | input | 1 | Level interrupt request |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |

## Verification
The bench lets the program counter run from 0xFEDC across the top of memory. Along the way it checks a load whose address bytes straddle the wrap, so a design that carried the counter wrongly, or that swapped the high and low address bytes, would read the wrong operand. An unlisted opcode sits in the stream, and a design that decoded it as anything other than a no-op would add reads or writes. The bench holds the interrupt request high for several cycles past the acknowledge: a design that did not mask requests would re-enter the handler and produce a second acknowledge. The return at the end of the handler must resume at the address after the halt, so a design that saved the wrong counter value, or restored it wrongly, would fetch from the wrong place.

// File: rtl/acc_pkg.sv
// Package: shared state encoding, control bundle and opcode values for the
// byte-serial accumulator controller. Assumes 8-bit opcodes.
package acc_pkg;

    localparam logic [7:0] OP_NOP   = 8'h00;
    localparam logic [7:0] OP_LOAD  = 8'h01;
    localparam logic [7:0] OP_STORE = 8'h02;
    localparam logic [7:0] OP_RETI  = 8'h10;
    localparam logic [7:0] OP_HALT  = 8'hFF;

    typedef enum logic [3:0] {
        ST_CHECK,   // instruction boundary: interrupt check, start fetch
        ST_INTR,    // take interrupt
        ST_OP_RD,   // opcode read strobe
        ST_OP_CAP,  // opcode capture
        ST_DECODE,  // move opcode to instruction register, dispatch
        ST_HI_RD,   // high address byte read strobe
        ST_HI_CAP,  // high address byte capture
        ST_LO_RD,   // low address byte read strobe
        ST_LO_CAP,  // low address byte capture, form operand address
        ST_EXEC,    // data read or data write
        ST_EX_CAP   // load data capture
    } seq_state_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ea;
        logic pc_inc;
        logic pc_vec;
        logic pc_restore;
        logic mbr_load;
        logic ir_load;
        logic hi_load;
        logic acc_load;
        logic save_ctx;
        logic reti;
        logic rd;
        logic wr;
        logic ack;
    } ctrl_t;

endpackage

// File: rtl/acc_irq.sv
// Interrupt unit: holds the enable flag and the saved program counter.
// Assumes save_ctx and reti are never raised in the same cycle.
module acc_irq #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_req,
    input  logic          save_ctx,
    input  logic          reti,
    input  logic [AW-1:0] pc,
    output logic          irq_take,
    output logic          ie_flag,
    output logic [AW-1:0] shadow_pc
);

    logic          ie_q;
    logic [AW-1:0] shadow_q;

    // Purpose: mask interrupts on entry and unmask them on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b1;
        end else if (save_ctx) begin
            ie_q <= 1'b0;
        end else if (reti) begin
            ie_q <= 1'b1;
        end
    end

    // Purpose: keep the program counter in effect when the interrupt was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (save_ctx) begin
            shadow_q <= pc;
        end
    end

    assign irq_take  = irq_req && ie_q;
    assign ie_flag   = ie_q;
    assign shadow_pc = shadow_q;

endmodule

// File: rtl/acc_dpath.sv
// Datapath: program counter, address register, buffer register, instruction
// register, high-address holding byte and accumulator. Driven only by the
// control bundle; assumes AW is twice DW.
module acc_dpath
    import acc_pkg::*;
#(
    parameter int              DW       = 8,
    parameter int              AW       = 2 * DW,
    parameter logic [AW-1:0]   RESET_PC = 16'hFEDC,
    parameter logic [AW-1:0]   VECTOR   = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] shadow_pc,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic [DW-1:0] acc
);

    logic [AW-1:0] pc_q, mar_q;
    logic [DW-1:0] mbr_q, ir_q, acc_q, hi_q;

    // Purpose: step, vector or restore the program counter (wraps naturally).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (ctrl.pc_vec) begin
            pc_q <= VECTOR;
        end else if (ctrl.pc_restore) begin
            pc_q <= shadow_pc;
        end else if (ctrl.pc_inc) begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Purpose: load the address register from the counter or the operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctrl.mar_from_ea) begin
            mar_q <= {hi_q, mem_rdata};
        end else if (ctrl.mar_from_pc) begin
            mar_q <= pc_q;
        end
    end

    // Purpose: capture each returned byte in the buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (ctrl.mbr_load) begin
            mbr_q <= mem_rdata;
        end
    end

    // Purpose: move the opcode from the buffer into the instruction register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= OP_NOP;
        end else if (ctrl.ir_load) begin
            ir_q <= mbr_q;
        end
    end

    // Purpose: hold the high operand-address byte until the low byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (ctrl.hi_load) begin
            hi_q <= mem_rdata;
        end
    end

    // Purpose: accumulator written by load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ctrl.acc_load) begin
            acc_q <= mem_rdata;
        end
    end

    assign pc  = pc_q;
    assign mar = mar_q;
    assign mbr = mbr_q;
    assign ir  = ir_q;
    assign acc = acc_q;

endmodule

// File: rtl/acc_seq.sv
// Sequencer: one state per memory strobe or capture; checks for interrupts
// at every instruction boundary and keeps the halt flag. Assumes memory
// returns read data one cycle after the strobe.
module acc_seq
    import acc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_take,
    input  logic [DW-1:0] mbr,
    input  logic [DW-1:0] ir,
    output ctrl_t         ctrl,
    output logic          halted
);

    seq_state_t state_q, state_d;
    logic       halted_q, halted_d;

    // Purpose: state and halt flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CHECK;
            halted_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            halted_q <= halted_d;
        end
    end

    // Purpose: next state, halt flag and control bundle for the current state.
    always_comb begin
        ctrl     = '0;
        state_d  = state_q;
        halted_d = halted_q;
        unique case (state_q)
            ST_CHECK: begin
                if (irq_take) begin
                    state_d = ST_INTR;
                end else if (!halted_q) begin
                    ctrl.mar_from_pc = 1'b1;
                    state_d          = ST_OP_RD;
                end
            end
            ST_INTR: begin
                ctrl.pc_vec   = 1'b1;
                ctrl.save_ctx = 1'b1;
                ctrl.ack      = 1'b1;
                halted_d      = 1'b0;
                state_d       = ST_CHECK;
            end
            ST_OP_RD: begin
                ctrl.rd     = 1'b1;
                ctrl.pc_inc = 1'b1;
                state_d     = ST_OP_CAP;
            end
            ST_OP_CAP: begin
                ctrl.mbr_load = 1'b1;
                state_d       = ST_DECODE;
            end
            ST_DECODE: begin
                ctrl.ir_load = 1'b1;
                state_d      = ST_CHECK;
                case (mbr)
                    OP_LOAD, OP_STORE: begin
                        ctrl.mar_from_pc = 1'b1;
                        state_d          = ST_HI_RD;
                    end
                    OP_HALT: halted_d = 1'b1;
                    OP_RETI: begin
                        ctrl.pc_restore = 1'b1;
                        ctrl.reti       = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_HI_RD: begin
                ctrl.rd     = 1'b1;
                ctrl.pc_inc = 1'b1;
                state_d     = ST_HI_CAP;
            end
            ST_HI_CAP: begin
                ctrl.mbr_load    = 1'b1;
                ctrl.hi_load     = 1'b1;
                ctrl.mar_from_pc = 1'b1;
                state_d          = ST_LO_RD;
            end
            ST_LO_RD: begin
                ctrl.rd     = 1'b1;
                ctrl.pc_inc = 1'b1;
                state_d     = ST_LO_CAP;
            end
            ST_LO_CAP: begin
                ctrl.mbr_load    = 1'b1;
                ctrl.mar_from_ea = 1'b1;
                state_d          = ST_EXEC;
            end
            ST_EXEC: begin
                if (ir == OP_LOAD) begin
                    ctrl.rd = 1'b1;
                    state_d = ST_EX_CAP;
                end else begin
                    ctrl.wr = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_EX_CAP: begin
                ctrl.mbr_load = 1'b1;
                ctrl.acc_load = 1'b1;
                state_d       = ST_CHECK;
            end
            default: state_d = ST_CHECK;
        endcase
    end

    assign halted = halted_q;

endmodule

// File: rtl/acc_fetch_ctrl.sv
// Top: byte-serial accumulator fetch-execute controller. Connects the
// sequencer, datapath and interrupt unit to a one-byte synchronous memory.
module acc_fetch_ctrl
    import acc_pkg::*;
#(
    parameter int                 DW       = 8,
    localparam int                AW       = 2 * DW,
    parameter logic [2*DW-1:0]    RESET_PC = 16'hFEDC,
    parameter logic [2*DW-1:0]    VECTOR   = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          irq_req,
    output logic          irq_ack
);

    ctrl_t         ctrl;
    logic          irq_take, ie_flag, halted;
    logic [AW-1:0] pc, mar, shadow_pc;
    logic [DW-1:0] mbr, ir, acc;

    acc_seq #(.DW(DW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_take (irq_take),
        .mbr      (mbr),
        .ir       (ir),
        .ctrl     (ctrl),
        .halted   (halted)
    );

    acc_dpath #(.DW(DW), .AW(AW), .RESET_PC(RESET_PC), .VECTOR(VECTOR)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mem_rdata (mem_rdata),
        .shadow_pc (shadow_pc),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .acc       (acc)
    );

    acc_irq #(.AW(AW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .save_ctx  (ctrl.save_ctx),
        .reti      (ctrl.reti),
        .pc        (pc),
        .irq_take  (irq_take),
        .ie_flag   (ie_flag),
        .shadow_pc (shadow_pc)
    );

    assign mem_addr  = mar;
    assign mem_rd    = ctrl.rd;
    assign mem_wr    = ctrl.wr;
    assign mem_wdata = acc;
    assign irq_ack   = ctrl.ack;

endmodule

// File: rtl/acc_fetch_ctrl_chk.sv
// Checker: temporal properties of the controller's memory and interrupt
// handshakes. Attached to every acc_fetch_ctrl instance through bind.
module acc_fetch_ctrl_chk #(
    parameter int            AW     = 16,
    parameter logic [AW-1:0] VECTOR = 16'h0010
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic          irq_ack,
    input logic          ie_flag,
    input logic          halted
);

    // R11: one strobe at a time
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11: a read is always followed by its capture cycle
    p_read_spaced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R8: acknowledge lasts one cycle
    p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R8: the fetch after an acknowledge is at the vector
    p_vector_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ##2 (mem_rd && mem_addr == VECTOR));

    // R9: entry masks further requests
    p_mask_on_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !ie_flag);

    // R9: no acknowledge while masked
    p_no_ack_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_flag |-> !irq_ack);

    // R7: halted controller strobes nothing
    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr));

endmodule

bind acc_fetch_ctrl acc_fetch_ctrl_chk #(.AW(AW), .VECTOR(VECTOR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .irq_ack  (irq_ack),
    .ie_flag  (ie_flag),
    .halted   (halted)
);

// File: tb/test_acc_fetch_ctrl.sv
// Bench: runs a program that climbs from 0xFEDC across the top of memory,
// halts, takes an interrupt and returns. The expected bus trace is built
// independently of the design.
module test_acc_fetch_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        irq_req = 1'b0;
    logic        irq_ack;

    int vecs = 0;
    int errs = 0;
    int ack_cnt = 0;
    int both_cnt = 0;
    bit done = 0;

    logic [7:0]  mem [int];
    logic [15:0] rd_log[$];
    logic [23:0] wr_log[$];
    logic [15:0] exp_rd[$];
    logic [23:0] exp_wr[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_fetch_ctrl i_acc_fetch_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack)
    );

    // Synchronous memory model: read data appears the cycle after the strobe.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        if (mem_wr) mem[int'(mem_addr)] = mem_wdata;
    end

    // Bus monitor, sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_log.push_back(mem_addr);
            if (mem_wr) wr_log.push_back({mem_addr, mem_wdata});
            if (irq_ack) ack_cnt++;
            if (mem_rd && mem_wr) both_cnt++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string rd_tag(input int idx, input logic [15:0] a);
        if (idx == 0)                          return "R1";
        if (a == 16'hA114 || a == 16'h1234)    return "R3";
        if (a >= 16'hFEE2 && a <= 16'hFFFD)    return "R5";
        if (a >= 16'hFFFE || a <= 16'h0003)    return "R6";
        if (a >= 16'h0010 && a <= 16'h0013)    return "R8";
        if (a == 16'h0005)                     return "R10";
        return "R2";
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errs++;
            vecs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int pre_n;
        // Program image.
        mem[16'hFEDC] = 8'h01; mem[16'hFEDD] = 8'hA1; mem[16'hFEDE] = 8'h14; // load A114
        mem[16'hA114] = 8'h5A;
        mem[16'hFEDF] = 8'h02; mem[16'hFEE0] = 8'h02; mem[16'hFEE1] = 8'h00; // store 0200
        mem[16'hFEE2] = 8'h37;                                               // unlisted opcode
        mem[16'hFFFE] = 8'h01; mem[16'hFFFF] = 8'h12; mem[16'h0000] = 8'h34; // load 1234, wraps
        mem[16'h1234] = 8'hC3;
        mem[16'h0001] = 8'h02; mem[16'h0002] = 8'h03; mem[16'h0003] = 8'h00; // store 0300
        mem[16'h0004] = 8'hFF; mem[16'h0005] = 8'hFF;                        // halts
        mem[16'h0010] = 8'h02; mem[16'h0011] = 8'h04; mem[16'h0012] = 8'h00; // handler: store 0400
        mem[16'h0013] = 8'h10;                                               // return

        // Expected read trace, from the requirements.
        exp_rd = '{16'hFEDC, 16'hFEDD, 16'hFEDE, 16'hA114, 16'hFEDF, 16'hFEE0, 16'hFEE1};
        for (int a = 16'hFEE2; a <= 16'hFFFD; a++) exp_rd.push_back(16'(a));
        exp_rd.push_back(16'hFFFE); exp_rd.push_back(16'hFFFF); exp_rd.push_back(16'h0000);
        exp_rd.push_back(16'h1234); exp_rd.push_back(16'h0001); exp_rd.push_back(16'h0002);
        exp_rd.push_back(16'h0003); exp_rd.push_back(16'h0004);
        pre_n = exp_rd.size();
        exp_rd.push_back(16'h0010); exp_rd.push_back(16'h0011); exp_rd.push_back(16'h0012);
        exp_rd.push_back(16'h0013); exp_rd.push_back(16'h0005);
        exp_wr = '{{16'h0200, 8'h5A}, {16'h0300, 8'hC3}, {16'h0400, 8'hC3}};

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rd in reset", 32'(mem_rd), 32'd0);
        chk("R1 wr in reset", 32'(mem_wr), 32'd0);
        chk("R1 ack in reset", 32'(irq_ack), 32'd0);
        rst_n = 1'b1;

        // Run until the first halt is reached.
        for (int c = 0; c < 5000 && rd_log.size() < pre_n; c++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R7 no reads while halted", 32'(rd_log.size()), 32'(pre_n));
        chk("R7 writes before interrupt", 32'(wr_log.size()), 32'd2);
        chk("R8 no ack before request", 32'(ack_cnt), 32'd0);

        // R8/R9: request held past the acknowledge.
        irq_req = 1'b1;
        for (int c = 0; c < 20 && !irq_ack; c++) @(negedge clk);
        chk("R8 ack seen", 32'(irq_ack), 32'd1);
        repeat (6) @(negedge clk);
        irq_req = 1'b0;
        repeat (80) @(negedge clk);
        chk("R9 single ack while masked", 32'(ack_cnt), 32'd1);
        chk("R11 strobes exclusive", 32'(both_cnt), 32'd0);

        // Compare the traces.
        chk("R2 read count", 32'(rd_log.size()), 32'(exp_rd.size()));
        for (int i = 0; i < exp_rd.size(); i++) begin
            chk(rd_tag(i, exp_rd[i]), (i < rd_log.size()) ? 32'(rd_log[i]) : 32'hDEAD, 32'(exp_rd[i]));
        end
        chk("R4 write count", 32'(wr_log.size()), 32'(exp_wr.size()));
        for (int i = 0; i < exp_wr.size(); i++) begin
            chk(i == 0 ? "R4" : (i == 1 ? "R3" : "R8"),
                (i < wr_log.size()) ? 32'(wr_log[i]) : 32'hDEAD, 32'(exp_wr[i]));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule